// File: doc/BRIEF.md
# Widening Odd-Lane Vector Adder

This block takes one 32-bit instruction word and two source vectors of a parameterised length. In every double-width result lane it adds the two signed narrow lanes that sit in the upper half of that lane. The narrow lanes are the odd-numbered ones. It then writes the sum back at double width. A two-bit size code in the instruction picks the result lane width (16, 32 or 64 bits) at run time. The lower, even-numbered narrow lanes of both sources play no part in the result.

A small decoder is built in. It checks the fixed opcode bits, takes out the three 5-bit register indices and the size code, and raises one of two flags:

- a not-matched flag when the word is some other instruction;
- an undefined flag when the word matches but uses the reserved size.

In both flagged cases the result vector is forced to zero. All outputs come from one register stage and appear one clock after the inputs.

Top module: `odd_widen_adder`

## Requirements
- R1: Result lane e (of width W) is formed from the narrow lanes at index 2e+1 (width W/2) of both sources, i.e. source bits [(2e+1)*W/2 +: W/2].
- R2: Both narrow lanes are read as two's-complement values and sign-extended to W bits before the addition.
- R3: Each sum is truncated to W bits. Overflow wraps modulo 2^W and is never saturated.
- R4: Size code instr[23:22] selects W: 2'b01 gives 16, 2'b10 gives 32, 2'b11 gives 64.
- R5: When the word matches and the size code is 2'b00, undef_flag is 1 and result is all zero.
- R6: The even-indexed narrow lanes of both sources have no effect on result.
- R7: The word matches only when instr[31:24] = 8'b01000101, instr[21] = 0 and instr[15:10] = 6'b000001. Otherwise nomatch_flag is 1, undef_flag is 0 and result is all zero.
- R8: dst_idx = instr[4:0], srca_idx = instr[9:5] and srcb_idx = instr[20:16]. They are given whether or not the word matches.
- R9: All outputs are registered: they reflect the inputs sampled at the previous rising clock edge, and they are zero while rst_n is low.
- R10: Every one of the VLEN/W result lanes is written. The operation is unpredicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector |
| result | output | VLEN | Widened odd-lane sums |
| dst_idx | output | 5 | Destination register index |
| srca_idx | output | 5 | First source register index |
| srcb_idx | output | 5 | Second source register index |
| undef_flag | output | 1 | Matched word with reserved size |
| nomatch_flag | output | 1 | Word is not this operation |

## Verification
The embedded properties assume that reset is held low for at least one rising edge before the first word of interest. They also assume that instr, src_a and src_b settle well before each rising edge. The bench meets both conditions by holding reset over several edges and by changing every input only on the falling clock edge. Beyond that the properties place no limit on the data values. The stimulus therefore uses fully random operands, the sign-boundary patterns and opcode words with each fixed field disturbed in turn.

// File: rtl/owa_pkg.sv
package owa_pkg;

    typedef enum logic [1:0] {
        SZ_RSVD = 2'b00,
        SZ_W16  = 2'b01,
        SZ_W32  = 2'b10,
        SZ_W64  = 2'b11
    } owa_size_e;

    localparam logic [7:0] OPC_HI  = 8'b0100_0101;
    localparam logic       OPC_B21 = 1'b0;
    localparam logic [5:0] OPC_MID = 6'b00_0001;

    localparam int NUM_WIDTHS = 3;
    localparam int MIN_SRCW   = 8;

    typedef struct packed {
        logic      hit;
        owa_size_e size;
        logic [4:0] rd;
        logic [4:0] ra;
        logic [4:0] rb;
    } owa_dec_t;

endpackage

// File: rtl/owa_decode.sv
module owa_decode
    import owa_pkg::*;
(
    input  logic [31:0] word,
    output owa_dec_t    dec
);

    always_comb begin
        dec.hit  = (word[31:24] == OPC_HI) &&
                   (word[21] == OPC_B21) &&
                   (word[15:10] == OPC_MID);
        dec.size = owa_size_e'(word[23:22]);
        dec.rb   = word[20:16];
        dec.ra   = word[9:5];
        dec.rd   = word[4:0];
    end

endmodule

// File: rtl/owa_lanes.sv
module owa_lanes #(
    parameter int VLEN = 256,
    parameter int SRCW = 8
) (
    input  logic [VLEN-1:0] op_a,
    input  logic [VLEN-1:0] op_b,
    output logic [VLEN-1:0] sums
);

    localparam int DSTW  = 2 * SRCW;
    localparam int NLANE = VLEN / DSTW;

    for (genvar e = 0; e < NLANE; e++) begin : g_lane
        logic [SRCW-1:0] hi_a, hi_b;
        logic [DSTW-1:0] ext_a, ext_b;
        logic            unused_even_bits;

        assign hi_a  = op_a[(2*e+1)*SRCW +: SRCW];
        assign hi_b  = op_b[(2*e+1)*SRCW +: SRCW];
        assign ext_a = {{SRCW{hi_a[SRCW-1]}}, hi_a};
        assign ext_b = {{SRCW{hi_b[SRCW-1]}}, hi_b};
        assign sums[e*DSTW +: DSTW] = ext_a + ext_b;
        assign unused_even_bits = ^{op_a[2*e*SRCW +: SRCW], op_b[2*e*SRCW +: SRCW]};
    end

endmodule

// File: rtl/odd_widen_adder.sv
module odd_widen_adder
    import owa_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    output logic [VLEN-1:0] result,
    output logic [4:0]      dst_idx,
    output logic [4:0]      srca_idx,
    output logic [4:0]      srcb_idx,
    output logic            undef_flag,
    output logic            nomatch_flag
);

    if (VLEN % 128 != 0) begin : g_bad_vlen
        $error("VLEN must be a multiple of 128");
    end

    owa_dec_t dec;

    owa_decode u_dec (
        .word (instr),
        .dec  (dec)
    );

    logic [VLEN-1:0] width_sum [NUM_WIDTHS];

    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
        owa_lanes #(
            .VLEN (VLEN),
            .SRCW (MIN_SRCW << k)
        ) u_lanes (
            .op_a (src_a),
            .op_b (src_b),
            .sums (width_sum[k])
        );
    end

    logic [VLEN-1:0] nxt_result;
    logic            nxt_undef;
    logic            nxt_nomatch;

    always_comb begin
        nxt_result  = '0;
        nxt_undef   = 1'b0;
        nxt_nomatch = !dec.hit;
        if (dec.hit) begin
            unique case (dec.size)
                SZ_RSVD: nxt_undef  = 1'b1;
                SZ_W16:  nxt_result = width_sum[0];
                SZ_W32:  nxt_result = width_sum[1];
                SZ_W64:  nxt_result = width_sum[2];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            dst_idx      <= '0;
            srca_idx     <= '0;
            srcb_idx     <= '0;
            undef_flag   <= 1'b0;
            nomatch_flag <= 1'b0;
        end else begin
            result       <= nxt_result;
            dst_idx      <= dec.rd;
            srca_idx     <= dec.ra;
            srcb_idx     <= dec.rb;
            undef_flag   <= nxt_undef;
            nomatch_flag <= nxt_nomatch;
        end
    end

    AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch_flag |-> (result == '0)); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_flag && nomatch_flag)); // R7
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (result == '0)); // R5
    AST_UNDEF_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> ($past(instr[23:22]) == 2'b00)); // R5
    AST_DST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dst_idx == $past(instr[4:0]))); // R8
    AST_SRC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (srca_idx == $past(instr[9:5]) && srcb_idx == $past(instr[20:16]))); // R8

endmodule

// File: tb/odd_widen_adder_test.sv
module odd_widen_adder_test;

    localparam int VLEN = 256;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] BASE = 32'h4500_0400;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] src_a = '0;
    logic [VLEN-1:0] src_b = '0;
    logic [VLEN-1:0] result;
    logic [4:0]      dst_idx, srca_idx, srcb_idx;
    logic            undef_flag, nomatch_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    odd_widen_adder #(.VLEN(VLEN)) uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .src_a(src_a), .src_b(src_b),
        .result(result), .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
        .undef_flag(undef_flag), .nomatch_flag(nomatch_flag)
    );

    // {instr, expected nomatch, expected undef}
    localparam int NVEC = 10;
    localparam logic [33:0] VEC [NVEC] = '{
        {32'h4540_0400 | 32'h0001_0041, 1'b0, 1'b0},  // size 01
        {32'h4580_0400 | 32'h001F_03FF, 1'b0, 1'b0},  // size 10
        {32'h45C0_0400 | 32'h000A_0155, 1'b0, 1'b0},  // size 11
        {32'h4500_0400 | 32'h0003_0062, 1'b0, 1'b1},  // reserved size
        {32'h4440_0400,                 1'b1, 1'b0},  // top byte off
        {32'h4560_0400,                 1'b1, 1'b0},  // bit 21 set
        {32'h4540_0000,                 1'b1, 1'b0},  // bit 10 clear
        {32'h4540_0C00,                 1'b1, 1'b0},  // bit 11 set
        {32'h4540_8400,                 1'b1, 1'b0},  // bit 15 set
        {32'hC5C0_0400,                 1'b1, 1'b0}   // bit 31 set
    };

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [4:0] rb,
                                       input logic [4:0] ra, input logic [4:0] rd);
        return BASE | {8'h0, sz, 1'b0, rb, 6'h0, ra, rd};
    endfunction

    function automatic logic [VLEN-1:0] model(input logic [1:0] sz,
                                              input logic [VLEN-1:0] a,
                                              input logic [VLEN-1:0] b);
        logic [VLEN-1:0] acc = '0;
        int sw, rw;
        logic [63:0] m, av, bv, s;
        if (sz == 2'b00) return '0;
        sw = 8 << (sz - 1);
        rw = 2 * sw;
        m  = (64'd1 << sw) - 64'd1;
        for (int e = 0; e < VLEN / rw; e++) begin
            av = 64'(a >> ((2*e+1)*sw)) & m;
            bv = 64'(b >> ((2*e+1)*sw)) & m;
            if (av[sw-1]) av = av | ~m;
            if (bv[sw-1]) bv = bv | ~m;
            s = av + bv;
            if (rw < 64) s = s & ((64'd1 << rw) - 64'd1);
            acc = acc | (VLEN'(s) << (e*rw));
        end
        return acc;
    endfunction

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk_vec(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_sml(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b);
        @(negedge clk);
        instr = w; src_a = a; src_b = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: act=timeout exp=done");
        finish_run();
    end

    initial begin
        logic [VLEN-1:0] a, b, r1;
        // R9: reset state, inputs already active
        instr = mk(2'b01, 5'd3, 5'd4, 5'd5);
        src_a = '1; src_b = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_vec("R9 reset result", result, '0);
        chk_sml("R9 reset flags/idx", {17'h0, undef_flag, nomatch_flag, dst_idx, srca_idx, srcb_idx}, 32'h0);
        rst_n = 1'b1;

        // Table walk: R7 matching, R4/R5 sizes, R8 indices
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] w;
            w = VEC[i][33:2];
            a = rnd_vec(); b = rnd_vec();
            apply(w, a, b);
            chk_sml("R7 nomatch_flag", {31'h0, nomatch_flag}, {31'h0, VEC[i][1]});
            chk_sml("R5 undef_flag", {31'h0, undef_flag}, {31'h0, VEC[i][0]});
            chk_sml("R8 indices", {17'h0, dst_idx, srca_idx, srcb_idx},
                    {17'h0, w[4:0], w[9:5], w[20:16]});
            if (VEC[i][1] || VEC[i][0]) chk_vec("R5/R7 zero result", result, '0);
            else chk_vec("R4 result by size", result, model(w[23:22], a, b));
        end

        // R1 R2 R10: random operands at each legal size
        for (int sz = 1; sz <= 3; sz++) begin
            for (int k = 0; k < 20; k++) begin
                a = rnd_vec(); b = rnd_vec();
                apply(mk(2'(sz), 5'(k), 5'(k+1), 5'(k+2)), a, b);
                chk_vec("R1 R2 R10 random", result, model(2'(sz), a, b));
            end
        end

        // R3 R2: most negative pairs and largest positive pairs
        apply(mk(2'b01, 0, 0, 0), {32{8'h80}}, {32{8'h80}});
        chk_vec("R3 min+min w16", result, {16{16'hFF00}});
        apply(mk(2'b01, 0, 0, 0), {32{8'h7F}}, {32{8'h7F}});
        chk_vec("R3 max+max w16", result, {16{16'h00FE}});
        apply(mk(2'b10, 0, 0, 0), {16{16'h8000}}, {16{16'h8000}});
        chk_vec("R3 min+min w32", result, {8{32'hFFFF_0000}});
        apply(mk(2'b11, 0, 0, 0), {8{32'h8000_0000}}, {8{32'h8000_0000}});
        chk_vec("R3 min+min w64", result, {4{64'hFFFF_FFFF_0000_0000}});
        apply(mk(2'b11, 0, 0, 0), {8{32'h7FFF_FFFF}}, {8{32'h7FFF_FFFF}});
        chk_vec("R3 max+max w64", result, {4{64'h0000_0000_FFFF_FFFE}});
        apply(mk(2'b10, 0, 0, 0), {16{16'hFFFF}}, {16{16'h0001}});
        chk_vec("R3 wrap to zero w32", result, '0);

        // R6: even lanes re-randomised, odd lanes kept
        for (int sz = 1; sz <= 3; sz++) begin
            logic [VLEN-1:0] odd_mask;
            int sw;
            sw = 8 << (sz - 1);
            odd_mask = '0;
            for (int j = 1; j < VLEN / sw; j += 2)
                odd_mask = odd_mask | (VLEN'((65'd1 << sw) - 65'd1) << (j*sw));
            a = rnd_vec(); b = rnd_vec();
            apply(mk(2'(sz), 1, 2, 3), a, b);
            r1 = result;
            a = (a & odd_mask) | (rnd_vec() & ~odd_mask);
            b = (b & odd_mask) | (rnd_vec() & ~odd_mask);
            apply(mk(2'(sz), 1, 2, 3), a, b);
            chk_vec("R6 even lanes ignored", result, r1);
        end

        // R9: one-cycle latency, output follows the previous edge only
        @(negedge clk);
        a = rnd_vec(); b = rnd_vec();
        instr = mk(2'b11, 7, 8, 9); src_a = a; src_b = b;
        @(posedge clk);
        @(negedge clk);
        instr = 32'h0; src_a = '1; src_b = '1;
        chk_vec("R9 latency", result, model(2'b11, a, b));
        @(negedge clk);
        chk_sml("R9 next word", {31'h0, nomatch_flag}, 32'h1);

        // R9: reset mid-run clears outputs
        apply(mk(2'b01, 1, 1, 1), rnd_vec(), rnd_vec());
        rst_n = 1'b0;
        @(negedge clk);
        chk_vec("R9 reset again", result, '0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule